// File: doc/BRIEF.md
# Crossed-Select Grid Memory

A small word-addressed storage block built as a two-dimensional grid of identical cells. The incoming address splits into a row field and a column field. Each field feeds its own decoder, and each decoder drives a bus of select lines with at most one line high. A cell is chosen only where its row line and its column line are both high. This takes a single two-input AND per cell, so the cells carry no address logic of their own.

Data travels over one shared bidirectional bus. On a read, the chosen cell places its word on the bus with no clock delay. On a write, the chosen cell takes the word from the bus at the rising clock edge. At every other time, every cell leaves the bus undriven.

Contents are not initialised. A location must be written before its read value means anything.

Top module: `grid_mem`

## Requirements
- R1: With the default sizes, the 6-bit `addr` is split as follows: `addr[5:3]` picks one of 8 rows and `addr[2:0]` picks one of 8 columns. This gives 64 independently stored 8-bit words.
- R2: At most one row select line is high at any time, and at most one column select line is high at any time.
- R3: While `en` is high and reset is released, the row line numbered `addr[5:3]` is high. The column line numbered `addr[2:0]` is also high.
- R4: While `en` is low or `rst_n` is low, every row and column select line is low. In this state no cell drives the bus and no cell is written.
- R5: At a rising `clk` edge with `rst_n`, `en` and `wr` all high, the word on `data` is stored at `addr`. Every other word keeps its value.
- R6: With `en` high and `wr` low, the word stored at `addr` appears on `data` in the same cycle, with no clock edge needed.
- R7: When `en` is low, or when `wr` is high, the block drives no bit of `data`. The bus then carries only what an external driver or pull places on it.
- R8: A clock edge with `en` low and `wr` high leaves every stored word unchanged, whatever value is on `data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Active-low reset; while low, all select lines are forced low |
| en | input | 1 | Access enable; while low, no cell is selected |
| wr | input | 1 | 1 = write from bus, 0 = read onto bus |
| addr | input | 6 | Word address; the upper field is the row, the lower field is the column |
| data | inout | 8 | Shared bidirectional data bus |

## Verification
The bench builds the block with its default sizes: 3 row bits, 3 column bits and 8-bit words. With only 64 locations, every address can be written and read back in each phase. This lets the bench reach every row/column crossing, including the corners and the diagonal, under two distinct data patterns. Every seventh address is then rewritten, and the ignored-write phase covers every address, so a select that spills into a neighbouring cell shows up as a wrong word somewhere in the sweep. A pull-up on the bench side of the bus makes an undriven bus read as all ones. The stored patterns never equal all ones, so a cell that drives the bus when it should not is caught.

// File: rtl/gm_pkg.sv
package gm_pkg;

   typedef enum logic [1:0] {
      GM_IDLE  = 2'd0,
      GM_READ  = 2'd1,
      GM_WRITE = 2'd2
   } gm_op_e;

   function automatic gm_op_e gm_op(input logic live, input logic en, input logic wr);
      if (!(live && en)) return GM_IDLE;
      return wr ? GM_WRITE : GM_READ;
   endfunction

endpackage

// File: rtl/gm_onehot_dec.sv
module gm_onehot_dec #(
   parameter int SEL_W     = 3,
   parameter int DEC_STYLE = 0,
   localparam int LINES    = 1 << SEL_W
) (
   input  logic             act,
   input  logic [SEL_W-1:0] sel,
   output logic [LINES-1:0] lines
);

   generate
      if (SEL_W < 1) begin : g_bad
         $error("gm_onehot_dec: SEL_W must be at least 1");
      end
      if (DEC_STYLE == 0) begin : g_shift
         always_comb begin
            lines = '0;
            if (act) lines = LINES'(1) << sel;
         end
      end else begin : g_match
         for (genvar i = 0; i < LINES; i++) begin : g_line
            assign lines[i] = act && (sel == SEL_W'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/gm_cell.sv
module gm_cell #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              row_ln,
   input  logic              col_ln,
   input  logic              wr_cmd,
   input  logic              rd_cmd,
   inout  wire [DATA_W-1:0]  bus
);

   logic              hit;
   logic [DATA_W-1:0] word_q;

   assign hit = row_ln & col_ln;

   always_ff @(posedge clk) begin
      if (hit && wr_cmd) word_q <= bus;
   end

   assign bus = (hit && rd_cmd) ? word_q : {DATA_W{1'bz}};

endmodule

// File: rtl/grid_mem.sv
module grid_mem #(
   parameter int ROW_W     = 3,
   parameter int COL_W     = 3,
   parameter int DATA_W    = 8,
   parameter int DEC_STYLE = 0,
   localparam int ADDR_W   = ROW_W + COL_W,
   localparam int ROWS     = 1 << ROW_W,
   localparam int COLS     = 1 << COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   inout  wire [DATA_W-1:0]  data
);
   import gm_pkg::*;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("grid_mem: DATA_W must be at least 1");
      end
      if (ADDR_W > 12) begin : g_bad_size
         $error("grid_mem: grid larger than 4096 words");
      end
   endgenerate

   gm_op_e          op;
   logic            sel_act;
   logic            wr_cmd;
   logic            rd_cmd;
   logic [ROWS-1:0] row_ln;
   logic [COLS-1:0] col_ln;

   assign op      = gm_op(rst_n, en, wr);
   assign sel_act = (op != GM_IDLE);
   assign wr_cmd  = (op == GM_WRITE);
   assign rd_cmd  = (op == GM_READ);

   gm_onehot_dec #(.SEL_W(ROW_W), .DEC_STYLE(DEC_STYLE)) u_row_dec (
      .act   (sel_act),
      .sel   (addr[ADDR_W-1:COL_W]),
      .lines (row_ln)
   );

   gm_onehot_dec #(.SEL_W(COL_W), .DEC_STYLE(DEC_STYLE)) u_col_dec (
      .act   (sel_act),
      .sel   (addr[COL_W-1:0]),
      .lines (col_ln)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         gm_cell #(.DATA_W(DATA_W)) u_cell (
            .clk    (clk),
            .row_ln (row_ln[r]),
            .col_ln (col_ln[c]),
            .wr_cmd (wr_cmd),
            .rd_cmd (rd_cmd),
            .bus    (data)
         );
      end
   end

endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int ROWS   = 1 << ROW_W,
   localparam int COLS   = 1 << COL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [ADDR_W-1:0] addr,
   input logic [ROWS-1:0]   row_ln,
   input logic [COLS-1:0]   col_ln
);

   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_ln)); // R2
   AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col_ln)); // R2
   AST_ROW_MATCH:  assert property (@(posedge clk) disable iff (!rst_n)
                      en |-> row_ln[addr[ADDR_W-1:COL_W]]); // R3
   AST_COL_MATCH:  assert property (@(posedge clk) disable iff (!rst_n)
                      en |-> col_ln[addr[COL_W-1:0]]); // R3
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                      !en |-> ($countones(row_ln) == 0 && $countones(col_ln) == 0)); // R4

endmodule

bind grid_mem gm_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .addr   (addr),
   .row_ln (row_ln),
   .col_ln (col_ln)
);

// File: tb/tb_grid_mem.sv
module tb_grid_mem;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       wr = 1'b0;
   logic [5:0] addr = '0;
   logic       drv_en = 1'b0;
   logic [7:0] drv_val = '0;
   wire  [7:0] data;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   assign data = drv_en ? drv_val : 8'bz;
   pullup pu_bus[7:0] (data);

   grid_mem dut (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .wr    (wr),
      .addr  (addr),
      .data  (data)
   );

   function automatic logic [7:0] pat_a(input int a);
      return {2'b01, 6'(a)};
   endfunction

   function automatic logic [7:0] pat_b(input int a);
      return {2'b10, ~6'(a)};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [7:0] v, input logic ena);
      @(negedge clk);
      en = ena; wr = 1'b1; addr = 6'(a); drv_en = 1'b1; drv_val = v;
      @(negedge clk);
      drv_en = 1'b0; en = 1'b0; wr = 1'b0;
   endtask

   task automatic do_read(input int a, input logic [7:0] exp, input string req);
      @(negedge clk);
      en = 1'b1; wr = 1'b0; addr = 6'(a); drv_en = 1'b0;
      #2;
      chk(req, data, exp);
   endtask

   initial begin
      // reset: selection forced off, bus undriven (R4)
      en = 1'b1; wr = 1'b0; addr = 6'd9;
      repeat (3) @(negedge clk);
      #2 chk("R4 reset bus", data, 8'hFF);
      en = 1'b0;
      @(negedge clk) rst_n = 1'b1;

      // fill every word with pattern A, read all back (R5, R6)
      for (int a = 0; a < 64; a++) do_write(a, pat_a(a), 1'b1);
      for (int a = 0; a < 64; a++) do_read(a, pat_a(a), "R6 read pattern A");

      // explicit row/column split: row 2 col 5, row 7 col 0 (R1)
      do_read(6'o25, pat_a(6'o25), "R1 row2 col5");
      do_read(6'o70, pat_a(6'o70), "R1 row7 col0");

      // rewrite every 7th word with pattern B, others stay (R5)
      for (int a = 0; a < 64; a += 7) do_write(a, pat_b(a), 1'b1);
      for (int a = 0; a < 64; a++)
         do_read(a, (a % 7 == 0) ? pat_b(a) : pat_a(a), "R5 partial rewrite");

      // writes with en low are ignored (R8)
      for (int a = 0; a < 64; a++) do_write(a, 8'h00, 1'b0);
      for (int a = 0; a < 64; a++)
         do_read(a, (a % 7 == 0) ? pat_b(a) : pat_a(a), "R8 ignored write");

      // idle: bus released for several addresses (R7)
      for (int a = 0; a < 64; a += 9) begin
         @(negedge clk);
         en = 1'b0; wr = 1'b0; addr = 6'(a); drv_en = 1'b0;
         #2 chk("R7 idle bus", data, 8'hFF);
      end

      // during write only the bench drives the bus (R7)
      @(negedge clk);
      en = 1'b1; wr = 1'b1; addr = 6'd12; drv_en = 1'b1; drv_val = 8'h3C;
      #2 chk("R7 write bus", data, 8'h3C);
      @(negedge clk);
      drv_en = 1'b0;
      #2 chk("R7 write undriven", data, 8'hFF);
      en = 1'b0; wr = 1'b0;
      do_read(12, 8'h3C, "R5 capture");

      // combinational read follows address inside one cycle (R6)
      @(negedge clk);
      en = 1'b1; wr = 1'b0; addr = 6'd1;
      #2 chk("R6 same cycle a", data, pat_a(1));
      addr = 6'd7;
      #2 chk("R6 same cycle b", data, pat_b(7));
      @(negedge clk) en = 1'b0;

      // reset again with en high: bus released (R4)
      rst_n = 1'b0; en = 1'b1; addr = 6'd3;
      #2 chk("R4 reset reselect", data, 8'hFF);
      @(negedge clk) rst_n = 1'b1;
      #2 chk("R6 after reset", data, pat_a(3));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule